// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 style management transactions on a two-wire MDC/MDIO link so that a chip can read and write 16-bit registers in an external PHY. A one-cycle `start` strobe hands over a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the whole frame on its own. It divides the system clock down to MDC and drives MDIO through an output enable, so the pad can release the line whenever the PHY has to talk.

A read checks the turnaround bit for a PHY that is pulling the line low. If no PHY answers, the master clocks the bus 32 more times with MDIO released. It then ends the transaction with `err` set and `rd_data` forced to all ones. `busy` covers the whole transaction, and a one-cycle `done` pulse closes it.

The sequencer states and their transitions:
- `ST_IDLE` goes to `ST_PRE` when `start` arrives.
- `ST_PRE` goes to `ST_START`, then `ST_OPCODE`, then `ST_PHYAD`, then `ST_REGAD`.
- From `ST_REGAD`, a write goes to `ST_WR_TA`. A read goes to `ST_RD_TA`.
- A write continues `ST_WR_TA` to `ST_WR_DATA` to `ST_WR_TAIL`, and then back to `ST_IDLE`.
- From `ST_RD_TA`, the read goes to `ST_RD_DATA` when the line is low, and to `ST_FLUSH` when it is high.
- `ST_RD_DATA` goes to `ST_RD_TAIL`, and then back to `ST_IDLE`.
- `ST_FLUSH` goes back to `ST_IDLE`.

Every return to `ST_IDLE` pulses `done`.

Top module: `mdio_frame_master`

## Requirements
- R1: A synchronous active-high `rst` sets `mdc` high, `mdio_oe` low, and `busy`, `done` and `err` low. The sequencer returns to idle.
- R2: Every MDC low phase and every high phase lasts `HALF_PERIOD` system clocks. While the block is idle, `mdc` stays high and MDIO is released (`mdio_oe` = 0).
- R3: Each frame opens with 32 MDC cycles. In each of them the master drives MDIO to 1.
- R4: After the opening cycles the master drives 0 then 1. It then drives the opcode: 1,0 for a read (`is_read` = 1) or 0,1 for a write (`is_read` = 0).
- R5: Next come the 5 PHY address bits and then the 5 register address bits, each field most significant bit first.
- R6: MDIO (`mdio_out` and `mdio_oe`) changes only while `mdc` is low. It is held across each rising edge of MDC and through the high phase.
- R7: A write drives turnaround 1,0 and then the 16 data bits, most significant first. It then releases MDIO for one further MDC cycle, so the frame has 65 MDC cycles in total.
- R8: A read releases MDIO from the turnaround cycle onward. It samples `mdio_in` at the end of each high phase. A low level in turnaround is followed by 16 data bits, most significant first, and two trailing cycles (65 cycles in total). `rd_data` then holds the value and `err` is 0.
- R9: If `mdio_in` is high when the read turnaround is sampled, 32 more MDC cycles follow with MDIO released (79 in total). The read then ends with `err` = 1 and `rd_data` = 16'hFFFF.
- R10: `busy` rises on the clock that accepts `start`. A single-cycle `done` pulse ends the transaction, and `busy` is already low during that cycle. `mdc` is high when `done` pulses.
- R11: A `start` that arrives while `busy` is high is ignored. The frame in progress is unchanged, and only one `done` pulse follows.
- R12: `rd_data` and `err` hold their values after `done` until the next accepted `start`. That `start` clears `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transaction request strobe; taken only when idle |
| is_read | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address inside the PHY |
| wr_data | input | 16 | Data for a write |
| rd_data | output | 16 | Data from the last read (all ones on a missing PHY) |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Last read found no PHY |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value while driven |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_in | input | 1 | Level seen on the MDIO line |

## Verification
The bench builds the block with `HALF_PERIOD` = 3. That value makes each MDC phase span several system clocks, so a phase that is one clock too short or too long shows up in the measured lengths. It also lets the bench check that MDIO stays still in the clocks between rising and falling MDC.

The bench plays the PHY itself, with a pull-up on the released line. It runs:
- writes to every one of the 32 PHY addresses;
- reads from 32 registers with a PHY present;
- several reads with no PHY attached.

On each frame it compares every recorded MDC cycle with the frame it has computed. Some of the frames also carry a stray `start` injected while the frame is running.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_START,
        ST_OPCODE,
        ST_PHYAD,
        ST_REGAD,
        ST_WR_TA,
        ST_WR_DATA,
        ST_WR_TAIL,
        ST_RD_TA,
        ST_RD_DATA,
        ST_RD_TAIL,
        ST_FLUSH
    } mdio_state_t;

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    generate
        if (HALF_PERIOD <= 1) begin : g_direct
            // every clock ends a half period
            assign tick = run;
        end else begin : g_count
            localparam int CNT_W = $clog2(HALF_PERIOD);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);
            logic [CNT_W-1:0] cnt_q;

            assign tick = run && (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || !run || tick) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PRE_LEN   = 32,
    parameter int FLUSH_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mdio_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe
);

    localparam int TX_W  = 2 * ADDR_W + 2 + DATA_W;
    localparam int BIT_W = $clog2(PRE_LEN + FLUSH_LEN + DATA_W + 1);
    localparam logic [BIT_W-1:0] ONE = BIT_W'(1);

    mdio_state_t      state_q, state_nx;
    logic [BIT_W-1:0] bit_q, bit_nx;
    logic [BIT_W-1:0] len;
    logic             slot_end;
    logic             last_bit;
    logic             finish;
    logic             rd_q;
    logic [TX_W-1:0]  tx_q;
    logic             nx_val, nx_en, nx_shift;

    // cycles spent in each state
    always_comb begin
        unique case (state_q)
            ST_PRE:     len = BIT_W'(PRE_LEN);
            ST_START:   len = BIT_W'(2);
            ST_OPCODE:  len = BIT_W'(2);
            ST_PHYAD:   len = BIT_W'(ADDR_W);
            ST_REGAD:   len = BIT_W'(ADDR_W);
            ST_WR_TA:   len = BIT_W'(2);
            ST_WR_DATA: len = BIT_W'(DATA_W);
            ST_WR_TAIL: len = BIT_W'(1);
            ST_RD_TA:   len = BIT_W'(1);
            ST_RD_DATA: len = BIT_W'(DATA_W);
            ST_RD_TAIL: len = BIT_W'(2);
            ST_FLUSH:   len = BIT_W'(FLUSH_LEN);
            default:    len = BIT_W'(1);
        endcase
    end

    assign slot_end = tick && mdc;
    assign last_bit = (bit_q == len - ONE);

    // next state and bit position
    always_comb begin
        state_nx = state_q;
        bit_nx   = bit_q;
        finish   = 1'b0;
        if (state_q == ST_IDLE) begin
            if (start) begin
                state_nx = ST_PRE;
                bit_nx   = '0;
            end
        end else if (slot_end) begin
            if (last_bit) begin
                bit_nx = '0;
                unique case (state_q)
                    ST_PRE:     state_nx = ST_START;
                    ST_START:   state_nx = ST_OPCODE;
                    ST_OPCODE:  state_nx = ST_PHYAD;
                    ST_PHYAD:   state_nx = ST_REGAD;
                    ST_REGAD:   state_nx = rd_q ? ST_RD_TA : ST_WR_TA;
                    ST_WR_TA:   state_nx = ST_WR_DATA;
                    ST_WR_DATA: state_nx = ST_WR_TAIL;
                    ST_RD_TA:   state_nx = mdio_in ? ST_FLUSH : ST_RD_DATA;
                    ST_RD_DATA: state_nx = ST_RD_TAIL;
                    ST_WR_TAIL, ST_RD_TAIL, ST_FLUSH: begin
                        state_nx = ST_IDLE;
                        finish   = 1'b1;
                    end
                    default:    state_nx = ST_IDLE;
                endcase
            end else begin
                bit_nx = bit_q + ONE;
            end
        end
    end

    // what the line carries in the slot about to begin
    always_comb begin
        nx_val   = 1'b0;
        nx_en    = 1'b0;
        nx_shift = 1'b0;
        unique case (state_nx)
            ST_PRE: begin
                nx_val = 1'b1;
                nx_en  = 1'b1;
            end
            ST_START: begin
                nx_val = (bit_nx != '0);
                nx_en  = 1'b1;
            end
            ST_OPCODE: begin
                nx_val = rd_q ? (bit_nx == '0) : (bit_nx != '0);
                nx_en  = 1'b1;
            end
            ST_PHYAD, ST_REGAD, ST_WR_TA, ST_WR_DATA: begin
                nx_val   = tx_q[TX_W-1];
                nx_en    = 1'b1;
                nx_shift = 1'b1;
            end
            default: begin
                nx_val = 1'b0;
                nx_en  = 1'b0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_nx;
            bit_q   <= bit_nx;
        end
    end

    // outputs and captured command
    always_ff @(posedge clk) begin
        if (rst) begin
            mdc      <= 1'b1;
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            rd_data  <= '0;
            rd_q     <= 1'b0;
            tx_q     <= '0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (start) begin
                    busy     <= 1'b1;
                    err      <= 1'b0;
                    rd_q     <= is_read;
                    tx_q     <= {phy_addr, reg_addr, 2'b10, wr_data};
                    mdc      <= 1'b0;
                    mdio_out <= 1'b1;
                    mdio_oe  <= 1'b1;
                end
            end else if (tick) begin
                if (!mdc) begin
                    mdc <= 1'b1;
                end else begin
                    if (state_q == ST_RD_DATA) begin
                        rd_data <= {rd_data[DATA_W-2:0], mdio_in};
                    end
                    if (finish) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        mdio_oe <= 1'b0;
                        if (state_q == ST_FLUSH) begin
                            err     <= 1'b1;
                            rd_data <= '1;
                        end
                    end else begin
                        mdc      <= 1'b0;
                        mdio_oe  <= nx_en;
                        mdio_out <= nx_val;
                        if (nx_shift) begin
                            tx_q <= {tx_q[TX_W-2:0], 1'b0};
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
    parameter int HALF_PERIOD = 4,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int PRE_LEN     = 32,
    parameter int FLUSH_LEN   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);

    logic tick;

    mdio_mdc_div #(
        .HALF_PERIOD(HALF_PERIOD)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    mdio_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PRE_LEN  (PRE_LEN),
        .FLUSH_LEN(FLUSH_LEN)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .start    (start),
        .is_read  (is_read),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .mdio_in  (mdio_in),
        .rd_data  (rd_data),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: rtl/mdio_frame_checker.sv
module mdio_frame_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              mdc,
    input logic              mdio_out,
    input logic              mdio_oe
);

    // R2: idle lines
    a_r2_idle_lines: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mdc && !mdio_oe));

    // R3: first slot drives a one with MDC low
    a_r3_first_slot: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mdio_oe && mdio_out && !mdc));

    // R6: MDIO still while MDC stays high
    a_r6_hold_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    // R10: done lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: done closes a busy period
    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy) && mdc));

    // R9: an error always comes with all-ones data
    a_r9_err_data: assert property (@(posedge clk) disable iff (rst)
        (err && !busy) |-> (rd_data == '1));

    // R11: a strobe during a frame does not break it
    a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

endmodule

bind mdio_frame_master mdio_frame_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_data  (rd_data),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
);

// File: tb/sim_mdio_frame_master.sv
module sim_mdio_frame_master;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_read = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        busy, done, err, mdc, mdio_out, mdio_oe;
    logic        mdio_in;

    // PHY model
    logic        phy_present = 1'b0;
    logic [15:0] phy_reg = '0;
    logic        phy_drv = 1'b0;
    logic        phy_bit = 1'b1;
    logic        cur_rd = 1'b0;

    assign mdio_in = mdio_oe ? mdio_out : (phy_drv ? phy_bit : 1'b1);

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_frame_master #(.HALF_PERIOD(H)) u0 (
        .clk(clk), .rst(rst), .start(start), .is_read(is_read),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done), .err(err),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // monitor
    logic rec_val [0:127];
    logic rec_oe  [0:127];
    int   slot = -1;
    int   rises = 0;
    int   toggles = 0;
    int   ph_len = 0;
    int   ph_bad = 0;
    int   stab_bad = 0;
    int   done_cnt = 0;
    logic p_mdc = 1'b1, p_out = 1'b0, p_oe = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mdc != p_mdc) begin
                if (toggles > 0 && ph_len != H) ph_bad++;
                toggles++;
                ph_len = 1;
                if (!mdc) begin
                    slot++;
                    if (phy_present && cur_rd && slot >= 46 && slot <= 62) begin
                        phy_drv = 1'b1;
                        phy_bit = (slot == 46) ? 1'b0 : phy_reg[62 - slot];
                    end else begin
                        phy_drv = 1'b0;
                        phy_bit = 1'b1;
                    end
                end else if (slot >= 0 && slot < 128) begin
                    rec_val[slot] = mdio_in;
                    rec_oe[slot]  = mdio_oe;
                    rises++;
                end
            end else begin
                ph_len++;
                if (mdc && (mdio_out != p_out || mdio_oe != p_oe)) stab_bad++;
            end
            if (done) done_cnt++;
        end
        p_mdc = mdc;
        p_out = mdio_out;
        p_oe  = mdio_oe;
    end

    function automatic logic [31:0] grab(input int lo, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r = {r[30:0], rec_val[lo + i]};
        return r;
    endfunction

    function automatic logic [31:0] grab_oe(input int lo, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r = {r[30:0], rec_oe[lo + i]};
        return r;
    endfunction

    task automatic frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input bit present,
                         input logic [15:0] preg, input int poke);
        logic [15:0] held_data;
        logic        held_err;
        bit          seen;
        int          n;
        @(negedge clk);
        slot = -1; rises = 0; toggles = 0; ph_bad = 0; stab_bad = 0; done_cnt = 0;
        phy_present = present; phy_reg = preg; cur_rd = rd;
        is_read = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", 32'(busy), 32'd1);
        check(err == 1'b0, "R12 err cleared by start", 32'(err), 32'd0);
        seen = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (c == poke) begin
                start = 1'b1; is_read = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
            end else begin
                start = 1'b0;
            end
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
        start = 1'b0;
        check(seen, "R10 done seen", 32'(seen), 32'd1);
        check(!busy && mdc, "R10 busy low, mdc high at done", {30'd0, busy, mdc}, 32'd1);
        check(ph_bad == 0, "R2 phase length", 32'(ph_bad), 32'd0);
        check(stab_bad == 0, "R6 mdio stable while mdc high", 32'(stab_bad), 32'd0);
        check(grab(0, 32) == 32'hFFFF_FFFF && grab_oe(0, 32) == 32'hFFFF_FFFF,
              "R3 preamble", grab(0, 32), 32'hFFFF_FFFF);
        check(grab(32, 4) == (rd ? 32'h6 : 32'h5), "R4 start/opcode", grab(32, 4),
              rd ? 32'h6 : 32'h5);
        check(grab(36, 10) == {22'd0, pa, ra}, "R5 addresses", grab(36, 10),
              {22'd0, pa, ra});
        check(grab_oe(32, 14) == 32'h3FFF, "R5 header driven", grab_oe(32, 14), 32'h3FFF);
        if (!rd) begin
            check(rises == 65, "R7 write cycle count", 32'(rises), 32'd65);
            check(grab(46, 18) == {14'd0, 2'b10, wd}, "R7 turnaround and data",
                  grab(46, 18), {14'd0, 2'b10, wd});
            check(grab_oe(46, 18) == 32'h3FFFF && rec_oe[64] == 1'b0, "R7 release tail",
                  {grab_oe(46, 18)}, 32'h3FFFF);
        end else if (present) begin
            check(rises == 65, "R8 read cycle count", 32'(rises), 32'd65);
            check(rd_data == preg && !err, "R8 read data", {15'd0, err, rd_data},
                  {16'd0, preg});
            check(grab_oe(46, 19) == 32'd0, "R8 released", grab_oe(46, 19), 32'd0);
        end else begin
            check(rises == 79, "R9 flush cycle count", 32'(rises), 32'd79);
            check(rd_data == 16'hFFFF && err, "R9 error result", {15'd0, err, rd_data},
                  {15'd0, 1'b1, 16'hFFFF});
            check(grab_oe(46, 32) == 32'd0, "R9 released during flush",
                  grab_oe(46, 32), 32'd0);
        end
        held_data = rd_data;
        held_err  = err;
        for (n = 0; n < 20; n++) @(negedge clk);
        check(done_cnt == 1, "R11 single done", 32'(done_cnt), 32'd1);
        check(rd_data == held_data && err == held_err && !busy, "R12 results held",
              {15'd0, err, rd_data}, {15'd0, held_err, held_data});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mdc && !mdio_oe && !busy && !done && !err, "R1 reset state",
              {27'd0, mdc, mdio_oe, busy, done, err}, 32'h10);
        check(mdc && !mdio_oe, "R2 idle lines", {30'd0, mdc, mdio_oe}, 32'h2);

        for (int a = 0; a < 32; a++) begin
            frame(1'b0, 5'(a), 5'(31 - a), 16'(a * 16'h0841) ^ 16'hA5C3, 1'b0, 16'h0,
                  (a % 8 == 3) ? 150 : -1);
        end
        for (int a = 0; a < 32; a++) begin
            frame(1'b1, 5'(a * 7), 5'(a), ~16'(a * 16'h1357), 1'b1, ~16'(a * 16'h1357),
                  (a % 8 == 5) ? 170 : -1);
        end
        frame(1'b1, 5'd0, 5'd1, 16'h0, 1'b1, 16'h0000, -1);
        frame(1'b1, 5'd31, 5'd31, 16'h0, 1'b1, 16'hFFFF, -1);
        frame(1'b1, 5'd3, 5'd2, 16'h0, 1'b0, 16'h0, -1);
        frame(1'b1, 5'd17, 5'd9, 16'h0, 1'b0, 16'h0, 200);
        frame(1'b0, 5'd4, 5'd4, 16'h8001, 1'b0, 16'h0, -1);
        frame(1'b1, 5'd30, 5'd0, 16'h0, 1'b0, 16'h0, -1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule